// File: doc/BRIEF.md
# Cache Line Maintenance Engine

This block holds the tag, valid, dirty and data state of a small set-associative write-back data cache. It runs maintenance commands against that state. A command selects clean, invalidate, or clean-and-invalidate, or a no-op encoding. The command targets one line, named either by an address that is looked up in the tags or directly by a set and way index. A dirty line that has to be cleaned is pushed out over a memory write port with a valid/ready handshake. A single-cycle done pulse ends every command and reports whether a valid line was found.

A fill port stands in for the normal load/store path. It writes a line's tag, data and dirty flag at a chosen set and way. Software-style flows use the engine one command at a time: issue the command, wait for done, then issue the next.

The controller is a three-state machine:
- ST_IDLE accepts a command (transition IDLE→LOOK).
- ST_LOOK reads the target set and decides. It goes LOOK→WB when a dirty line must be written back. Otherwise it goes LOOK→IDLE, updating the line and pulsing done.
- ST_WB presents the writeback. It stays there while memory stalls, and goes WB→IDLE on the handshake, updating the line and pulsing done.

Top module: `cmm_engine`

## Requirements
- R1: `cmd_op` bit 0 requests a clean and bit 1 requests an invalidate. 2'b01 is clean, 2'b10 is invalidate, 2'b11 is clean-and-invalidate, and 2'b00 changes nothing. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until done, including every writeback stall cycle.
- R2: By address, the set is `cmd_addr[OFF_W+IDX_W-1:OFF_W]` and the tag is the top TAG_W bits; the low OFF_W bits are ignored. The command hits when a valid way of that set holds the tag, and the lowest-numbered matching way is chosen. A miss pulses done one cycle after acceptance, with `done_hit` low and no memory traffic.
- R3: With `cmd_by_sw` high, the command acts on the line at `cmd_set`/`cmd_way` (both counted from 0), whatever tag it holds. It counts as a hit when that line is valid.
- R4: A clean that hits a dirty line raises `wb_valid` two cycles after acceptance. `wb_addr` is {line tag, set, OFF_W zero bits} and `wb_data` is the line data. done pulses in the handshake cycle, and the line then stays valid with its dirty bit cleared.
- R5: A clean that hits a line that is not dirty writes nothing back and pulses done one cycle after acceptance.
- R6: An invalidate that hits drops the line with no writeback, even if it is dirty. Valid and dirty both end cleared, and done pulses one cycle after acceptance.
- R7: Clean-and-invalidate writes back a dirty line exactly as R4 does, then leaves the line invalid. On a line that is not dirty it acts as R6.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold steady and done stays low.
- R9: A fill with `fill_valid` high while the engine is idle and `cache_en` is high writes the line valid, with the given tag, data and dirty flag. Fills while `cache_en` is low, or while a command is in flight, are ignored.
- R10: Maintenance does not depend on `cache_en`. An invalidate by address with the cache disabled still removes a matching line.
- R11: done is high for exactly one cycle per command, `done_hit` is valid with it, and `cmd_ready` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid and dirty bits |
| cache_en | input | 1 | Cache enable, gates fills only |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Bit 0 clean, bit 1 invalidate |
| cmd_by_sw | input | 1 | 1: target by set/way, 0: by address |
| cmd_addr | input | ADDR_W | Target address |
| cmd_set | input | IDX_W | Target set index |
| cmd_way | input | WAY_W | Target way index |
| done | output | 1 | Command complete pulse |
| done_hit | output | 1 | Target line was valid (and matched) |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Memory accepts writeback |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | DATA_W | Writeback line data |
| fill_valid | input | 1 | Fill stub write request |
| fill_set | input | IDX_W | Fill set |
| fill_way | input | WAY_W | Fill way |
| fill_tag | input | TAG_W | Fill tag |
| fill_data | input | DATA_W | Fill data |
| fill_dirty | input | 1 | Fill marks line dirty |

## Verification
When no writeback is needed, done and `done_hit` are due in the first cycle after the accepting edge. A writeback shows up on the port in the second cycle, and done coincides with the cycle in which `wb_ready` is high. `cmd_ready` returns one cycle after done. The bench drives at falling edges and samples there, stepping exactly that many falling edges from the accepting one. It holds `wb_ready` low for a sweep-chosen number of cycles to check the stall window. Line state left behind by each command is then read out through a set/way clean, whose hit and writeback reveal the remaining valid and dirty bits.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WB   = 2'd2
    } state_e;

    localparam int OP_CLEAN_BIT = 0;
    localparam int OP_INV_BIT   = 1;
endpackage

// File: rtl/cmm_line_store.sv
module cmm_line_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 rd_set,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0]                  rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]      rd_data,
    input  logic                             fill_we,
    input  logic [IDX_W-1:0]                 fill_set,
    input  logic [WAY_W-1:0]                 fill_way,
    input  logic [TAG_W-1:0]                 fill_tag,
    input  logic [DATA_W-1:0]                fill_data,
    input  logic                             fill_dirty,
    input  logic                             mt_we,
    input  logic [IDX_W-1:0]                 mt_set,
    input  logic [WAY_W-1:0]                 mt_way,
    input  logic                             mt_clr_valid,
    input  logic                             mt_clr_dirty
);
    logic [SETS-1:0][WAYS-1:0]  valid_q, dirty_q;
    logic [TAG_W-1:0]           tag_q  [SETS][WAYS];
    logic [DATA_W-1:0]          data_q [SETS][WAYS];

    // Status bits: maintenance has priority over the fill stub.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (mt_we) begin
            if (mt_clr_valid) valid_q[mt_set][mt_way] <= 1'b0;
            if (mt_clr_dirty) dirty_q[mt_set][mt_way] <= 1'b0;
        end else if (fill_we) begin
            valid_q[fill_set][fill_way] <= 1'b1;
            dirty_q[fill_set][fill_way] <= fill_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we && !mt_we) begin
            tag_q[fill_set][fill_way]  <= fill_tag;
            data_q[fill_set][fill_way] <= fill_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = valid_q[rd_set][w];
        assign rd_dirty[w] = dirty_q[rd_set][w];
        assign rd_tag[w]   = tag_q[rd_set][w];
        assign rd_data[w]  = data_q[rd_set][w];
    end
endmodule

// File: rtl/cmm_tag_match.sv
module cmm_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    // Lowest-numbered matching way wins.
    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/cmm_engine.sv
module cmm_engine #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_by_sw,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [IDX_W-1:0]  cmd_set,
    input  logic [WAY_W-1:0]  cmd_way,
    output logic              done,
    output logic              done_hit,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty
);
    import cmm_pkg::*;

    state_e             state_q, state_d;
    logic [1:0]         op_q;
    logic               sw_q;
    logic [IDX_W-1:0]   set_q;
    logic [WAY_W-1:0]   way_q;
    logic [TAG_W-1:0]   tag_q;

    logic [WAYS-1:0]              rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
    logic [WAYS-1:0][DATA_W-1:0]  rd_data;
    logic                         match_hit;
    logic [WAY_W-1:0]             match_way;
    logic [WAY_W-1:0]             tgt_way;
    logic                         line_hit, line_dirty, need_wb;
    logic                         accept, fill_we, mt_we;
    logic                         unused_offset;

    assign unused_offset = ^cmd_addr[OFF_W-1:0];
    assign accept  = cmd_valid && cmd_ready;
    assign fill_we = fill_valid && cache_en && (state_q == ST_IDLE);

    cmm_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_set       (set_q),
        .rd_valid     (rd_valid),
        .rd_dirty     (rd_dirty),
        .rd_tag       (rd_tag),
        .rd_data      (rd_data),
        .fill_we      (fill_we),
        .fill_set     (fill_set),
        .fill_way     (fill_way),
        .fill_tag     (fill_tag),
        .fill_data    (fill_data),
        .fill_dirty   (fill_dirty),
        .mt_we        (mt_we),
        .mt_set       (set_q),
        .mt_way       (tgt_way),
        .mt_clr_valid (op_q[OP_INV_BIT]),
        .mt_clr_dirty (|op_q)
    );

    cmm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
        .valid   (rd_valid),
        .tags    (rd_tag),
        .tag     (tag_q),
        .hit     (match_hit),
        .hit_way (match_way)
    );

    // Target line: store contents cannot change while a command is in flight.
    assign tgt_way    = sw_q ? way_q : match_way;
    assign line_hit   = sw_q ? rd_valid[way_q] : match_hit;
    assign line_dirty = rd_dirty[tgt_way];
    assign need_wb    = line_hit && line_dirty && op_q[OP_CLEAN_BIT];

    // Command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            sw_q  <= 1'b0;
            set_q <= '0;
            way_q <= '0;
            tag_q <= '0;
        end else if (accept) begin
            op_q  <= cmd_op;
            sw_q  <= cmd_by_sw;
            set_q <= cmd_by_sw ? cmd_set : cmd_addr[OFF_W +: IDX_W];
            way_q <= cmd_way;
            tag_q <= cmd_addr[ADDR_W-1 -: TAG_W];
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)   state_d = ST_LOOK;
            ST_LOOK: state_d = need_wb ? ST_WB : ST_IDLE;
            ST_WB:   if (wb_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        cmd_ready = 1'b0;
        wb_valid  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_LOOK: done      = !need_wb;
            ST_WB: begin
                wb_valid = 1'b1;
                done     = wb_ready;
            end
            default: ;
        endcase
        done_hit = done && line_hit;
        mt_we    = done && line_hit;
        wb_addr  = {rd_tag[tgt_way], set_q, {OFF_W{1'b0}}};
        wb_data  = rd_data[tgt_way];
    end

    // R1: a pending writeback keeps the command port closed.
    p_busy_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !cmd_ready);
    // R5: only a dirty line under a clean request reaches the memory port.
    p_wb_only_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (op_q[OP_CLEAN_BIT] && line_dirty && line_hit));
    // R4: a clean-only hit leaves the line valid and no longer dirty.
    p_clean_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && line_hit && op_q == 2'b01) |=>
            (rd_valid[$past(tgt_way)] && !rd_dirty[$past(tgt_way)]));
    // R6: an invalidate hit leaves the line gone.
    p_inv_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && line_hit && op_q[OP_INV_BIT]) |=>
            (!rd_valid[$past(tgt_way)] && !rd_dirty[$past(tgt_way)]));
    // R8: writeback held stable under backpressure.
    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
    // R11: done is a single pulse and the port reopens after it.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));
endmodule

// File: tb/cmm_engine_tb.sv
module cmm_engine_tb_top;
    localparam int SETS = 4, WAYS = 2, ADDR_W = 10, OFF_W = 2, DATA_W = 16;
    localparam int TAG_W = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cache_en = 1'b1, cmd_valid = 1'b0, cmd_by_sw = 1'b0, wb_ready = 1'b0;
    logic [1:0] cmd_op = '0, cmd_set = '0, fill_set = '0;
    logic cmd_way = 1'b0, fill_way = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic cmd_ready, done, done_hit, wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    int vectors = 0, errors = 0;
    bit busy_fill = 0;

    bit mv[4][2], md[4][2];
    logic [TAG_W-1:0] mt[4][2];
    logic [DATA_W-1:0] mdat[4][2];

    always #4 clk = ~clk;

    cmm_engine #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_by_sw(cmd_by_sw), .cmd_addr(cmd_addr), .cmd_set(cmd_set), .cmd_way(cmd_way),
        .done(done), .done_hit(done_hit),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_data(fill_data), .fill_dirty(fill_dirty)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(logic [1:0] s, logic w, logic [TAG_W-1:0] t,
                           logic [DATA_W-1:0] d, logic dy);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = s; fill_way = w;
        fill_tag = t; fill_data = d; fill_dirty = dy;
        @(negedge clk);
        fill_valid = 1'b0;
        if (cache_en) begin
            mv[s][w] = 1'b1; md[s][w] = dy; mt[s][w] = t; mdat[s][w] = d;
        end
    endtask

    task automatic do_cmd(logic [1:0] op, logic sw, logic [1:0] s, logic w,
                          logic [TAG_W-1:0] t, int stall);
        bit hit;
        int way;
        bit ewb;
        string rq;
        hit = 0; way = 0;
        if (sw) begin
            way = int'(w); hit = mv[s][w];
        end else begin
            for (int i = 1; i >= 0; i--)
                if (mv[s][i] && mt[s][i] == t) begin hit = 1; way = i; end
        end
        ewb = hit && md[s][way] && op[0];
        rq = (op == 2'b01) ? (ewb ? "R4" : "R5") : (op == 2'b10) ? "R6" :
             (op == 2'b11) ? "R7" : "R1";
        if (!hit && !sw) rq = "R2";
        if (sw && op == 2'b01 && !ewb) rq = "R3";

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_by_sw = sw; cmd_set = s; cmd_way = w;
        cmd_addr = {t, s, 2'b01};
        chk("R1 ready before accept", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (busy_fill) fill_valid = 1'b1;
        chk("R1 ready low while busy", 32'(cmd_ready), 32'd0);
        if (!ewb) begin
            chk({rq, " done one cycle after accept"}, 32'(done), 32'd1);
            chk({rq, " done_hit"}, 32'(done_hit), 32'(hit));
            chk({rq, " no writeback"}, 32'(wb_valid), 32'd0);
            @(negedge clk);
        end else begin
            chk({rq, " no done before writeback"}, 32'(done), 32'd0);
            @(negedge clk);
            chk({rq, " wb_valid"}, 32'(wb_valid), 32'd1);
            chk({rq, " wb_addr"}, 32'(wb_addr), 32'({mt[s][way], s, 2'b00}));
            chk({rq, " wb_data"}, 32'(wb_data), 32'(mdat[s][way]));
            for (int k = 0; k < stall; k++) begin
                chk("R8 done held low in stall", 32'(done), 32'd0);
                chk("R8 ready low in stall", 32'(cmd_ready), 32'd0);
                @(negedge clk);
                chk("R8 wb_valid held", 32'(wb_valid), 32'd1);
                chk("R8 wb_addr held", 32'(wb_addr), 32'({mt[s][way], s, 2'b00}));
            end
            wb_ready = 1'b1;
            #1;
            chk({rq, " done with handshake"}, 32'(done), 32'd1);
            chk({rq, " done_hit with handshake"}, 32'(done_hit), 32'd1);
            @(negedge clk);
            wb_ready = 1'b0;
        end
        fill_valid = 1'b0;
        chk("R11 single done pulse", 32'(done), 32'd0);
        chk("R11 ready after done", 32'(cmd_ready), 32'd1);
        if (hit && op != 2'b00) begin
            md[s][way] = 1'b0;
            if (op[1]) mv[s][way] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; mdat[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        chk("R11 reset ready", 32'(cmd_ready), 32'd1);
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R4 reset wb_valid", 32'(wb_valid), 32'd0);
        rst_n = 1'b1;
        // Reset leaves every line invalid: set/way clean finds nothing (R3).
        do_cmd(2'b01, 1'b1, 2'd2, 1'b1, '0, 0);

        // Sweep every op, both targeting modes, every line.
        for (int op = 0; op < 4; op++)
            for (int sw = 0; sw < 2; sw++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 2; w++) begin
                        logic [TAG_W-1:0] t;
                        t = TAG_W'((s * 2 + w) * 5 + op * 7 + sw);
                        do_fill(2'(s), 1'(w), t, DATA_W'(16'hA000 + op * 256 + s * 16 + w),
                                1'((s + w + op) % 2));
                        do_cmd(2'(op), 1'(sw), 2'(s), 1'(w), t, (s + w) % 3);
                        // Probe remaining state via set/way clean (R3, R9).
                        do_cmd(2'b01, 1'b1, 2'(s), 1'(w), '0, 0);
                    end

        // Address miss: no traffic, line untouched (R2).
        do_fill(2'd0, 1'b0, 6'd3, 16'h1234, 1'b1);
        do_fill(2'd0, 1'b1, 6'd4, 16'h5678, 1'b1);
        do_cmd(2'b11, 1'b0, 2'd0, 1'b0, 6'd9, 0);
        do_cmd(2'b01, 1'b1, 2'd0, 1'b0, '0, 2);
        do_cmd(2'b10, 1'b0, 2'd0, 1'b1, 6'd4, 0);
        do_cmd(2'b01, 1'b1, 2'd0, 1'b1, '0, 0);

        // Duplicate tags: lowest way chosen (R2).
        do_fill(2'd1, 1'b0, 6'd12, 16'hAAAA, 1'b1);
        do_fill(2'd1, 1'b1, 6'd12, 16'hBBBB, 1'b1);
        do_cmd(2'b01, 1'b0, 2'd1, 1'b0, 6'd12, 1);
        do_cmd(2'b01, 1'b0, 2'd1, 1'b0, 6'd12, 0);
        do_cmd(2'b01, 1'b1, 2'd1, 1'b1, '0, 0);

        // Cache disabled: fill ignored (R9), invalidate still removes (R10).
        do_fill(2'd2, 1'b1, 6'd20, 16'hC0DE, 1'b1);
        cache_en = 1'b0;
        do_fill(2'd2, 1'b1, 6'd21, 16'hDEAD, 1'b0);
        do_cmd(2'b01, 1'b0, 2'd2, 1'b1, 6'd21, 0);
        do_cmd(2'b10, 1'b0, 2'd2, 1'b1, 6'd20, 0);
        do_cmd(2'b01, 1'b1, 2'd2, 1'b1, '0, 0);
        chk("R10 line removed while disabled", 32'(mv[2][1]), 32'd0);
        cache_en = 1'b1;

        // Fill during a busy command is ignored (R9).
        do_cmd(2'b10, 1'b1, 2'd3, 1'b0, '0, 0);
        do_fill(2'd3, 1'b1, 6'd30, 16'hF00D, 1'b1);
        fill_set = 2'd3; fill_way = 1'b0; fill_tag = 6'd31;
        fill_data = 16'h0BAD; fill_dirty = 1'b1;
        busy_fill = 1;
        do_cmd(2'b01, 1'b1, 2'd3, 1'b1, '0, 3);
        busy_fill = 0;
        do_cmd(2'b01, 1'b1, 2'd3, 1'b0, '0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule